// File: doc/BRIEF.md
# Rotate and Mask Generator

This unit serves the shift and bit-field datapath of a 16-bit word machine. For each accepted operation it takes a data word, a signed shift count and a mask code. It returns the data word rotated left by the count modulo the word width, together with a contiguous run of ones that the field logic downstream uses to select bits. The mask is right-justified (ones from bit 0 upward) or left-justified (ones from the MSB downward), as a select input chooses.

The rotate has two stages. A fine stage rotates by 0 to 3 places, then a coarse stage rotates by 0, 4, 8 or 12 places. A negative count stands for a right shift and becomes the equivalent left rotate. If the count's magnitude is larger than the word width minus one, the shift is abandoned and the data result is zero. The mask is still produced in that case. Inputs are accepted on a cycle with `in_valid` high. The results appear one clock later, with a one-cycle `out_valid` pulse, and hold until the next accepted operation.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted input, `out_valid`, `out_data` and `out_mask` are all zero.
- R2: An input accepted on a clock edge with `in_valid` high produces `out_valid` high for exactly the following cycle. Without a new accept, `out_valid` is low.
- R3: For a shift count s in 0..15, `out_data` is `in_data` rotated left by s.
- R4: For a shift count s in -15..-1, `out_data` is `in_data` rotated left by 16+s. This equals a right rotate by -s.
- R5: For a shift count of 16 or more, or of -16 or less (`in_shift` is 6-bit two's complement), `out_data` is 0x0000.
- R6: With `in_left` = 0, mask code k (0..15) gives `out_mask` with bits k..0 set and all other bits clear. For example, 0 gives 0x0001 and 15 gives 0xFFFF.
- R7: With `in_left` = 1, `in_mcode` holds a count n of ones, where 0 means 16. `out_mask` then has bits 15..16-n set and all other bits clear. For example, 1 gives 0x8000 and 0 gives 0xFFFF.
- R8: The mask is delivered with every result, including one whose data output was forced to zero under R5.
- R9: On a cycle without `in_valid`, `out_data` and `out_mask` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are captured on this edge |
| in_data | input | 16 | Word to rotate |
| in_shift | input | 6 | Signed shift count, two's complement |
| in_mcode | input | 4 | Mask code (right mode) or count of ones (left mode) |
| in_left | input | 1 | 1 selects the left-justified mask |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 16 | Rotated word, or zero when the count is out of range |
| out_mask | output | 16 | Contiguous ones mask |

## Verification
Each result is due exactly one clock after the edge that accepts its input, because a single register stage follows the combinational rotate and mask logic. The bench drives inputs on the falling edge and samples all three outputs just after the next rising edge. Its hold checks sample again one full cycle later, after `in_valid` has dropped. Expected words come from a bit-loop rotate and a bit-loop mask builder in the bench. Each result is compared in its own due cycle, so an extra or missing register stage shows up as a mismatch.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int WORD_W  = 16;
  localparam int SHIFT_W = 6;
  localparam int AMT_W   = $clog2(WORD_W);
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rm_fine_rot.sv
module rm_fine_rot #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   amt,
  output logic [W-1:0] dout
);
  logic [W-1:0] cand [4];

  for (genvar k = 0; k < 4; k++) begin : g_step
    if (k == 0) begin : g_zero
      assign cand[k] = din;
    end else begin : g_rot
      assign cand[k] = {din[W-1-k:0], din[W-1:W-k]};
    end
  end

  always_comb begin
    dout = cand[amt];
  end
endmodule

// File: rtl/rm_coarse_rot.sv
module rm_coarse_rot #(
  parameter int W = 16
) (
  input  logic [W-1:0]             din,
  input  logic [$clog2(W)-3:0]     amt,
  output logic [W-1:0]             dout
);
  localparam int STEPS = W / 4;
  logic [W-1:0] cand [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_nib
    localparam int K = 4 * g;
    if (K == 0) begin : g_zero
      assign cand[g] = din;
    end else begin : g_rot
      assign cand[g] = {din[W-1-K:0], din[W-1:W-K]};
    end
  end

  always_comb begin
    dout = cand[amt];
  end
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int W = 16,
  localparam int AW = $clog2(W)
) (
  input  logic [AW-1:0] code,
  input  logic          left,
  output logic [W-1:0]  mask
);
  logic [AW-1:0] sel_code;
  logic [W-1:0]  rj;

  // left mode: count n becomes code (0 - n) mod W before the table
  always_comb begin
    sel_code = left ? (AW'(0) - code) : code;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rj[i] = (AW'(i) <= sel_code);
  end

  // left mode: invert, then shift right one place with a 1 entering at the MSB
  always_comb begin
    mask = left ? {1'b1, ~rj[W-1:1]} : rj;
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [AMT_W-1:0]   in_mcode,
  input  logic               in_left,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_data,
  output logic [WORD_W-1:0]  out_mask
);
  localparam int MAXMAG = WORD_W - 1;

  logic [AMT_W-1:0] amt;
  logic             too_far;
  word_t            fine_q, rot_w, mask_w;
  word_t            data_d, mask_d;
  logic             vld_d;

  // two's complement low bits give (16 + s) for negative counts
  always_comb begin
    amt     = in_shift[AMT_W-1:0];
    too_far = ($signed(in_shift) > MAXMAG) || ($signed(in_shift) < -MAXMAG);
  end

  rm_fine_rot #(.W(WORD_W)) u_fine (
    .din (in_data),
    .amt (amt[1:0]),
    .dout(fine_q)
  );

  rm_coarse_rot #(.W(WORD_W)) u_coarse (
    .din (fine_q),
    .amt (amt[AMT_W-1:2]),
    .dout(rot_w)
  );

  rm_mask_gen #(.W(WORD_W)) u_mask (
    .code(in_mcode),
    .left(in_left),
    .mask(mask_w)
  );

  always_comb begin
    vld_d  = in_valid;
    data_d = out_data;
    mask_d = out_mask;
    if (in_valid) begin
      data_d = too_far ? '0 : rot_w;
      mask_d = mask_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mask  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= data_d;
      out_mask  <= mask_d;
    end
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_zero_far_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && too_far) |=> (out_data == '0));
  p_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !too_far) |=> ($countones(out_data) == $countones($past(in_data))));
  p_rmask_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_left) |=> out_mask[0]);
  p_lmask_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left) |=> out_mask[WORD_W-1]);
  p_mask_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_mask)));
endmodule

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [5:0]  in_shift;
  logic [3:0]  in_mcode;
  logic        in_left;
  logic        out_valid;
  logic [15:0] out_data;
  logic [15:0] out_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rotmask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_shift(in_shift), .in_mcode(in_mcode), .in_left(in_left),
    .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask)
  );

  function automatic logic [15:0] ref_rotl(input logic [15:0] d, input int r);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[(i + r) % 16] = d[i];
    return o;
  endfunction

  function automatic logic [15:0] ref_low_ones(input int n);
    logic [15:0] o = '0;
    for (int i = 0; i < n; i++) o[i] = 1'b1;
    return o;
  endfunction

  function automatic logic [15:0] ref_high_ones(input int n);
    logic [15:0] o = '0;
    for (int i = 0; i < n; i++) o[15 - i] = 1'b1;
    return o;
  endfunction

  task automatic chk(input string req, input logic ok, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive on falling edge, result due right after next rising edge
  task automatic issue(input logic [15:0] d, input int s, input int code, input logic lf);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_shift = 6'(s); in_mcode = 4'(code); in_left = lf;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid == 1'b0, {15'd0, out_valid}, 16'h0);
    chk("R1 data", out_data == 16'h0, out_data, 16'h0);
    chk("R1 mask", out_mask == 16'h0, out_mask, 16'h0);
  endtask

  task automatic t_pos_rot;
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] d = 16'($urandom);
        issue(d, r, 15, 1'b0);
        chk("R2 pulse", out_valid == 1'b1, {15'd0, out_valid}, 16'h1);
        chk("R3 rotate", out_data == ref_rotl(d, r), out_data, ref_rotl(d, r));
      end
    end
    @(posedge clk); #1;
    chk("R2 pulse ends", out_valid == 1'b0, {15'd0, out_valid}, 16'h0);
  endtask

  task automatic t_neg_rot;
    for (int s = -15; s < 0; s++) begin
      logic [15:0] d = 16'($urandom);
      issue(d, s, 3, 1'b0);
      chk("R4 neg rotate", out_data == ref_rotl(d, 16 + s), out_data, ref_rotl(d, 16 + s));
    end
  endtask

  task automatic t_far;
    int cnt [6] = '{16, 17, 31, -16, -17, -32};
    foreach (cnt[i]) begin
      issue(16'hFFFF, cnt[i], 5, 1'b0);
      chk("R5 zeroed", out_data == 16'h0, out_data, 16'h0);
      chk("R8 mask kept", out_mask == 16'h003F, out_mask, 16'h003F);
    end
    issue(16'hA5C3, 16, 2, 1'b1);
    chk("R8 left mask kept", out_mask == 16'hC000, out_mask, 16'hC000);
  endtask

  task automatic t_rmask;
    for (int k = 0; k < 16; k++) begin
      issue(16'h1234, 0, k, 1'b0);
      chk("R6 right mask", out_mask == ref_low_ones(k + 1), out_mask, ref_low_ones(k + 1));
    end
  endtask

  task automatic t_lmask;
    for (int n = 0; n < 16; n++) begin
      int ones = (n == 0) ? 16 : n;
      issue(16'h1234, 1, n, 1'b1);
      chk("R7 left mask", out_mask == ref_high_ones(ones), out_mask, ref_high_ones(ones));
    end
  endtask

  task automatic t_hold;
    issue(16'h00F1, 4, 6, 1'b0);
    @(negedge clk);
    in_data = 16'hFFFF; in_shift = 6'd7; in_mcode = 4'd0; in_left = 1'b1;
    @(posedge clk); #1;
    chk("R9 data held", out_data == 16'h0F10, out_data, 16'h0F10);
    chk("R9 mask held", out_mask == 16'h007F, out_mask, 16'h007F);
    chk("R2 no pulse", out_valid == 1'b0, {15'd0, out_valid}, 16'h0);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_shift = '0; in_mcode = '0; in_left = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_pos_rot;
    t_neg_rot;
    t_far;
    t_rmask;
    t_lmask;
    t_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule